// File: doc/BRIEF.md
# Card Interface Power Sequencer and Clock Generator

This block sits between a register write port and the pins of a memory-card interface. It holds a small power state machine that decides whether the card pins float, are pulled low, are held high or are handed over to the command and data engines. It also divides a kernel clock down to the card clock. A 2-bit power code moves the machine between three states. After power-on, an enable output that the command and data engines use stays low until the card has seen a fixed number of clock rising edges.

The card clock is built inside the kernel clock domain. A nonzero divider N gives a high phase and a low phase of N kernel cycles each. A divider of zero hands the kernel clock straight to the card through a gate that is timed on the falling edge. A launch-edge flag and a one-cycle launch strobe tell the command and data output logic which card-clock edge to drive on. A power-save option parks the clock low while no engine is busy. A divider change only takes effect at the end of a high phase, or while the clock is parked low.

Top module: `card_pwr_clk`

## Requirements
- R1: After reset, pinMode is 0 (high impedance), the power register (address 0) reads 0, ifEnable is 0 and cardClk is low.
- R2: Writing power code bits[1:0] at address 0 selects the pin mode: 00 gives pinMode 2 (driven high), 10 gives pinMode 1 (driven low), 11 gives pinMode 3 (interface active). The new mode is visible in the cycle after the write.
- R3: Writing power code 01 changes nothing: the power register read-back, pinMode and ifEnable all keep their previous values.
- R4: In the active state, ifEnable rises in the same cycle as the 74th card-clock rising edge counted since entry, and not before. It falls in the cycle after any write that leaves the active state. Re-entering the active state restarts the count.
- R5: The clock register (address 1) holds the divider in bits[9:0], falling-edge select in bit 10, power-save in bit 11, 4-bit bus in bit 12 and 8-bit bus in bit 13. With a divider N > 0, each card-clock high phase and each low phase lasts exactly N kernel cycles.
- R6: With a divider of 0 in the active state, cardClk follows the kernel clock: high in the kernel high phase, low in the kernel low phase. launchOnFall is 1 and launchStrobe stays high.
- R7: With a nonzero divider, launchOnFall equals the falling-edge select bit. launchStrobe is high exactly in the kernel cycles in which cardClk has just taken its launch level: high when the select bit is 0, low when it is 1.
- R8: With power-save set, ifEnable high and engineBusy low, the card clock parks low. When engineBusy rises, the clock resumes with full N-cycle phases.
- R9: A divider change made while the clock runs produces only phases whose length is the old or the new divider. After the change has settled, phases use the new divider.
- R10: Outside the active state, cardClk is low from the second kernel cycle after the leaving write onward.
- R11: busWidth is 2 when the 8-bit bit is set (whatever the 4-bit bit), 1 when only the 4-bit bit is set, and 0 when neither is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 1 | Write address: 0 power, 1 clock |
| wrData | input | 14 | Write data |
| rdAddr | input | 1 | Read address |
| rdData | output | 14 | Read data of the addressed register |
| engineBusy | input | 1 | A command or data engine is active |
| cardClk | output | 1 | Card clock |
| pinMode | output | 2 | 0 hi-Z, 1 driven low, 2 driven high, 3 active |
| ifEnable | output | 1 | Interface enabled for command and data logic |
| launchStrobe | output | 1 | Marks the cycle in which the launch edge occurred |
| launchOnFall | output | 1 | Outputs launch on the card-clock falling edge |
| busWidth | output | 2 | 0 one lane, 1 four lanes, 2 eight lanes |

## Verification
The hardest case to reach from the ports is a divider rewrite that lands in the middle of a running phase. The stimulus issues the write from inside a sampling loop at a chosen cycle, so that the change arrives partway through a phase. It then checks the length of every complete phase against the old and new divider values. The parked power-save state is reached by first waiting out the full 74-edge hold-off, since the clock only parks once the interface is enabled. That hold-off is measured by counting observed rising edges up to the cycle in which ifEnable first appears.

// File: rtl/card_pwr_clk_pkg.sv
package card_pwr_clk_pkg;

  typedef enum logic [1:0] {
    PIN_HIZ    = 2'd0,
    PIN_LOW    = 2'd1,
    PIN_HIGH   = 2'd2,
    PIN_ACTIVE = 2'd3
  } pin_mode_e;

  typedef enum logic [1:0] {
    PWR_RESET,
    PWR_OFF,
    PWR_CYCLE,
    PWR_ON
  } pwr_state_e;

  localparam logic [1:0] CODE_OFF   = 2'b00;
  localparam logic [1:0] CODE_RSVD  = 2'b01;
  localparam logic [1:0] CODE_CYCLE = 2'b10;
  localparam logic [1:0] CODE_ON    = 2'b11;

  // strobes from control to clock datapath
  typedef struct packed {
    logic clkRun;   // clock may leave its low phase
    logic clkKill;  // force clock low, clear divider state
  } clk_ctrl_t;

endpackage

// File: rtl/card_pwr_ctrl.sv
module card_pwr_ctrl
  import card_pwr_clk_pkg::*;
#(
  parameter int DIV_W     = 10,
  parameter int HOLD_CLKS = 74,
  parameter int CFG_W     = DIV_W + 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrEn,
  input  logic             wrAddr,
  input  logic [CFG_W-1:0] wrData,
  input  logic             rdAddr,
  output logic [CFG_W-1:0] rdData,
  input  logic             engineBusy,
  input  logic             riseEv,
  output clk_ctrl_t        ctrl,
  output logic [DIV_W-1:0] divVal,
  output logic             fallSel,
  output logic [1:0]       pinMode,
  output logic             ifEnable,
  output logic [1:0]       busWidth
);

  localparam int HOLD_W   = $clog2(HOLD_CLKS + 1);
  localparam int FALL_BIT = DIV_W;
  localparam int SAVE_BIT = DIV_W + 1;
  localparam int W4_BIT   = DIV_W + 2;
  localparam int W8_BIT   = DIV_W + 3;
  localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(HOLD_CLKS);
  localparam logic [HOLD_W-1:0] HOLD_ONE  = HOLD_W'(1);

  pwr_state_e        pwrState;
  logic [1:0]        pwrCode;
  logic [DIV_W-1:0]  divReg;
  logic              fallReg, saveReg, w4Reg, w8Reg;
  logic [HOLD_W-1:0] holdCnt;
  logic              isOn;

  assign isOn = (pwrState == PWR_ON);

  // register write port and power state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwrState <= PWR_RESET;
      pwrCode  <= CODE_OFF;
      divReg   <= '0;
      fallReg  <= 1'b0;
      saveReg  <= 1'b0;
      w4Reg    <= 1'b0;
      w8Reg    <= 1'b0;
    end else if (wrEn) begin
      if (!wrAddr) begin
        if (wrData[1:0] != CODE_RSVD) begin
          pwrCode <= wrData[1:0];
          case (wrData[1:0])
            CODE_CYCLE: pwrState <= PWR_CYCLE;
            CODE_ON:    pwrState <= PWR_ON;
            default:    pwrState <= PWR_OFF;
          endcase
        end
      end else begin
        divReg  <= wrData[DIV_W-1:0];
        fallReg <= wrData[FALL_BIT];
        saveReg <= wrData[SAVE_BIT];
        w4Reg   <= wrData[W4_BIT];
        w8Reg   <= wrData[W8_BIT];
      end
    end
  end

  // hold-off: count card clock rising edges since entering power-on
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      holdCnt <= '0;
    end else if (!isOn) begin
      holdCnt <= '0;
    end else if (riseEv && (holdCnt != HOLD_LAST)) begin
      holdCnt <= holdCnt + HOLD_ONE;
    end
  end

  assign ifEnable     = isOn && (holdCnt == HOLD_LAST);
  assign ctrl.clkKill = !isOn;
  assign ctrl.clkRun  = isOn && !(saveReg && ifEnable && !engineBusy);
  assign divVal       = divReg;
  assign fallSel      = fallReg;
  assign busWidth     = w8Reg ? 2'd2 : (w4Reg ? 2'd1 : 2'd0);

  always_comb begin
    case (pwrState)
      PWR_OFF:   pinMode = PIN_HIGH;
      PWR_CYCLE: pinMode = PIN_LOW;
      PWR_ON:    pinMode = PIN_ACTIVE;
      default:   pinMode = PIN_HIZ;
    endcase
  end

  always_comb begin
    rdData = '0;
    if (!rdAddr) begin
      rdData[1:0] = pwrCode;
    end else begin
      rdData[DIV_W-1:0] = divReg;
      rdData[FALL_BIT]  = fallReg;
      rdData[SAVE_BIT]  = saveReg;
      rdData[W4_BIT]    = w4Reg;
      rdData[W8_BIT]    = w8Reg;
    end
  end

  AST_RSVD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && !wrAddr && wrData[1:0] == CODE_RSVD) |=> ($stable(pwrCode) && $stable(pwrState))); // R3
  AST_ENABLE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    ifEnable |-> (pinMode == PIN_ACTIVE)); // R4
  AST_HOLD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    holdCnt <= HOLD_LAST); // R4
  AST_ENABLE_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ifEnable) |-> $past(riseEv)); // R4

endmodule

// File: rtl/card_clk_gen.sv
module card_clk_gen
  import card_pwr_clk_pkg::*;
#(
  parameter int DIV_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  clk_ctrl_t        ctrl,
  input  logic [DIV_W-1:0] divVal,
  input  logic             fallSel,
  output logic             cardClk,
  output logic             riseEv,
  output logic             launchStrobe,
  output logic             launchOnFall
);

  localparam logic [DIV_W-1:0] DIV_ONE = DIV_W'(1);

  logic [DIV_W-1:0] activeDiv, cnt;
  logic clkReg, gateQ, strobeQ;
  logic bypass, divEnd, advance, toggleNow, bypassRun, loadDiv;

  assign bypass    = (activeDiv == '0);
  assign divEnd    = (cnt == activeDiv - DIV_ONE);
  assign advance   = clkReg || ctrl.clkRun;   // a high phase always completes
  assign toggleNow = !bypass && !ctrl.clkKill && advance && divEnd;
  assign bypassRun = bypass && ctrl.clkRun && !ctrl.clkKill;
  // divider reload only at a low-phase boundary or while parked low
  assign loadDiv   = ctrl.clkKill || bypass || (!clkReg && !ctrl.clkRun)
                   || (toggleNow && clkReg);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clkReg    <= 1'b0;
      cnt       <= '0;
      activeDiv <= '0;
      strobeQ   <= 1'b0;
    end else begin
      if (ctrl.clkKill) begin
        clkReg <= 1'b0;
        cnt    <= '0;
      end else if (toggleNow) begin
        clkReg <= !clkReg;
        cnt    <= '0;
      end else if (advance && !bypass) begin
        cnt <= cnt + DIV_ONE;
      end else begin
        cnt <= '0;
      end
      if (loadDiv) activeDiv <= divVal;
      strobeQ <= (toggleNow && (clkReg == fallSel)) || bypassRun;
    end
  end

  // bypass gate changes only while the kernel clock is low
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) gateQ <= 1'b0;
    else        gateQ <= bypassRun;
  end

  assign cardClk      = clkReg | (clk & gateQ);
  assign riseEv       = (toggleNow && !clkReg) || bypassRun;
  assign launchStrobe = strobeQ;
  assign launchOnFall = bypass || fallSel;

  AST_KILL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.clkKill |=> !clkReg); // R10
  AST_DIV_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (clkReg && $past(clkReg)) |-> $stable(activeDiv)); // R9
  AST_BYPASS_REG_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    bypass |-> !clkReg); // R6
  AST_STROBE_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (strobeQ && !$past(bypassRun)) |-> (clkReg != $past(clkReg))); // R7

endmodule

// File: rtl/card_pwr_clk.sv
module card_pwr_clk
  import card_pwr_clk_pkg::*;
#(
  parameter int DIV_W     = 10,
  parameter int HOLD_CLKS = 74,
  parameter int CFG_W     = DIV_W + 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrEn,
  input  logic             wrAddr,
  input  logic [CFG_W-1:0] wrData,
  input  logic             rdAddr,
  output logic [CFG_W-1:0] rdData,
  input  logic             engineBusy,
  output logic             cardClk,
  output logic [1:0]       pinMode,
  output logic             ifEnable,
  output logic             launchStrobe,
  output logic             launchOnFall,
  output logic [1:0]       busWidth
);

  clk_ctrl_t        ctrl;
  logic [DIV_W-1:0] divVal;
  logic             fallSel;
  logic             riseEv;

  card_pwr_ctrl #(.DIV_W(DIV_W), .HOLD_CLKS(HOLD_CLKS), .CFG_W(CFG_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .engineBusy(engineBusy), .riseEv(riseEv),
    .ctrl(ctrl), .divVal(divVal), .fallSel(fallSel), .pinMode(pinMode),
    .ifEnable(ifEnable), .busWidth(busWidth)
  );

  card_clk_gen #(.DIV_W(DIV_W)) gen_i (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .divVal(divVal), .fallSel(fallSel),
    .cardClk(cardClk), .riseEv(riseEv), .launchStrobe(launchStrobe),
    .launchOnFall(launchOnFall)
  );

endmodule

// File: tb/card_pwr_clk_tb_top.sv
module card_pwr_clk_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wrEn = 1'b0;
  logic        wrAddr = 1'b0;
  logic [13:0] wrData = '0;
  logic        rdAddr = 1'b0;
  logic [13:0] rdData;
  logic        engineBusy = 1'b0;
  logic        cardClk;
  logic [1:0]  pinMode;
  logic        ifEnable;
  logic        launchStrobe;
  logic        launchOnFall;
  logic [1:0]  busWidth;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;
  logic sClk [0:299];
  logic sStb [0:299];
  int badRun, lastRun, runCount;

  always #2.5 clk = ~clk;

  card_pwr_clk dut_i (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .engineBusy(engineBusy), .cardClk(cardClk),
    .pinMode(pinMode), .ifEnable(ifEnable), .launchStrobe(launchStrobe),
    .launchOnFall(launchOnFall), .busWidth(busWidth)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [13:0] clkWord(input int dv, input bit fall,
                                         input bit save, input bit w4, input bit w8);
    return 14'(dv) | (14'(fall) << 10) | (14'(save) << 11) | (14'(w4) << 12) | (14'(w8) << 13);
  endfunction

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic regWrite(input logic a, input logic [13:0] d);
    @(posedge clk); #1;
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  // sample n cycles at posedge+1, optionally writing the clock register at cycle wrAt
  task automatic capture(input int n, input int wrAt, input logic [13:0] wd);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      if (i == wrAt) begin wrEn = 1'b1; wrAddr = 1'b1; wrData = wd; end
      else wrEn = 1'b0;
      sClk[i] = cardClk;
      sStb[i] = launchStrobe;
    end
    wrEn = 1'b0;
  endtask

  // complete phase lengths must be a or b; first and last partial runs skipped
  task automatic runCheck(input int n, input int a, input int b);
    int runLen;
    bit first;
    runLen = 1; first = 1'b1; badRun = 0; lastRun = 0; runCount = 0;
    for (int i = 1; i < n; i++) begin
      if (sClk[i] == sClk[i-1]) runLen++;
      else begin
        if (!first) begin
          runCount++;
          lastRun = runLen;
          if (runLen != a && runLen != b && badRun == 0) badRun = runLen;
        end
        first = 1'b0;
        runLen = 1;
      end
    end
  endtask

  task automatic testReset();
    rdAddr = 1'b0; #1;
    chk(pinMode == 2'd0, "R1", "pinMode after reset", pinMode, 0);
    chk(rdData == 14'd0, "R1", "power field after reset", rdData, 0);
    chk(ifEnable == 1'b0, "R1", "ifEnable after reset", ifEnable, 0);
    chk(cardClk == 1'b0, "R1", "cardClk after reset", cardClk, 0);
  endtask

  task automatic testHoldOff();
    int rises;
    logic prev;
    int seenAt;
    regWrite(1'b1, clkWord(1, 0, 0, 0, 0));
    regWrite(1'b0, 14'b11);
    chk(pinMode == 2'd3, "R2", "pinMode on code 11", pinMode, 3);
    rises = 0; prev = cardClk; seenAt = -1;
    for (int i = 0; i < 400 && seenAt < 0; i++) begin
      tick();
      if (cardClk && !prev) rises++;
      prev = cardClk;
      if (ifEnable) seenAt = rises;
    end
    chk(seenAt == 74, "R4", "rising edges when ifEnable appears", seenAt, 74);
  endtask

  task automatic testReserved();
    regWrite(1'b0, 14'b01);
    rdAddr = 1'b0; #1;
    chk(rdData == 14'd3, "R3", "power field after code 01", rdData, 3);
    chk(pinMode == 2'd3, "R3", "pinMode after code 01", pinMode, 3);
    chk(ifEnable == 1'b1, "R3", "ifEnable after code 01", ifEnable, 1);
  endtask

  task automatic testDivide();
    int badStb, nStb;
    regWrite(1'b1, clkWord(3, 0, 0, 0, 0));
    repeat (12) tick();
    capture(60, -1, '0);
    runCheck(60, 3, 3);
    chk(badRun == 0 && runCount >= 4, "R5", "phase length with divider 3", badRun, 3);
    badStb = 0; nStb = 0;
    for (int i = 1; i < 60; i++) begin
      if (sStb[i]) nStb++;
      if (sStb[i] != (sClk[i] && !sClk[i-1])) badStb++;
    end
    chk(badStb == 0 && nStb > 0, "R7", "strobe on rising edge mismatches", badStb, 0);
    chk(launchOnFall == 1'b0, "R7", "launchOnFall with select 0", launchOnFall, 0);
  endtask

  task automatic testFallEdge();
    int badStb, nStb;
    regWrite(1'b1, clkWord(2, 1, 0, 0, 0));
    repeat (6) tick();
    capture(40, -1, '0);
    badStb = 0; nStb = 0;
    for (int i = 1; i < 40; i++) begin
      if (sStb[i]) nStb++;
      if (sStb[i] != (!sClk[i] && sClk[i-1])) badStb++;
    end
    chk(badStb == 0 && nStb > 0, "R7", "strobe on falling edge mismatches", badStb, 0);
    chk(launchOnFall == 1'b1, "R7", "launchOnFall with select 1", launchOnFall, 1);
  endtask

  task automatic testDivChange();
    regWrite(1'b1, clkWord(5, 0, 0, 0, 0));
    repeat (20) tick();
    capture(80, 13, clkWord(2, 0, 0, 0, 0));
    runCheck(80, 2, 5);
    chk(badRun == 0, "R9", "phase length during divider change", badRun, 2);
    chk(lastRun == 2, "R9", "phase length after change", lastRun, 2);
  endtask

  task automatic testPowerSave();
    int highs;
    regWrite(1'b1, clkWord(3, 0, 1, 0, 0));
    capture(40, -1, '0);
    highs = 0;
    for (int i = 20; i < 40; i++) if (sClk[i] || sStb[i]) highs++;
    chk(highs == 0, "R8", "clock activity while idle with power-save", highs, 0);
    engineBusy = 1'b1;
    capture(50, -1, '0);
    runCheck(50, 3, 3);
    chk(badRun == 0 && runCount >= 4, "R8", "phase length after restart", badRun, 3);
    engineBusy = 1'b0;
    regWrite(1'b1, clkWord(3, 0, 0, 0, 0));
  endtask

  task automatic testBypass();
    int bad;
    regWrite(1'b1, clkWord(0, 0, 0, 0, 0));
    repeat (10) tick();
    bad = 0;
    for (int i = 0; i < 8; i++) begin
      @(posedge clk); #1;
      if (cardClk !== 1'b1 || launchStrobe !== 1'b1) bad++;
      @(negedge clk); #1;
      if (cardClk !== 1'b0) bad++;
    end
    chk(bad == 0, "R6", "bypass clock samples wrong", bad, 0);
    chk(launchOnFall == 1'b1, "R6", "launchOnFall with divider 0", launchOnFall, 1);
  endtask

  task automatic testBusWidth();
    regWrite(1'b1, clkWord(4, 0, 0, 1, 0));
    chk(busWidth == 2'd1, "R11", "busWidth 4-bit", busWidth, 1);
    regWrite(1'b1, clkWord(4, 0, 0, 1, 1));
    chk(busWidth == 2'd2, "R11", "busWidth both bits", busWidth, 2);
    regWrite(1'b1, clkWord(4, 0, 0, 0, 0));
    chk(busWidth == 2'd0, "R11", "busWidth 1-bit", busWidth, 0);
    regWrite(1'b1, clkWord(0, 0, 0, 0, 0));
    repeat (10) tick();
  endtask

  task automatic lowCheck(input string req);
    int bad;
    bad = 0;
    tick();
    for (int i = 0; i < 5; i++) begin
      @(posedge clk); #1;
      if (cardClk !== 1'b0) bad++;
      @(negedge clk); #1;
      if (cardClk !== 1'b0) bad++;
    end
    chk(bad == 0, req, "cardClk high samples outside power-on", bad, 0);
  endtask

  task automatic testOffCycle();
    regWrite(1'b0, 14'b00);
    chk(pinMode == 2'd2, "R2", "pinMode on code 00", pinMode, 2);
    chk(ifEnable == 1'b0, "R4", "ifEnable after leaving power-on", ifEnable, 0);
    lowCheck("R10");
    regWrite(1'b0, 14'b10);
    chk(pinMode == 2'd1, "R2", "pinMode on code 10", pinMode, 1);
    lowCheck("R10");
    regWrite(1'b0, 14'b11);
    repeat (4) tick();
    chk(ifEnable == 1'b0, "R4", "ifEnable right after re-entry", ifEnable, 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    testReset();
    rst_n = 1'b1;
    tick();
    testReset();
    testHoldOff();
    testReserved();
    testDivide();
    testFallEdge();
    testDivChange();
    testPowerSave();
    testBypass();
    testBusWidth();
    testOffCycle();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule